// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block turns one host request into the sequence of bus write cycles that a parallel NOR flash expects for a command. It supports word program, sector erase, whole-chip erase, return to read-array, fast-program bypass entry and exit, and secure-region entry and exit. Each command begins with unlock writes to two fixed addresses. These addresses depend on the device's data width and are chosen from a width code that is captured with the request.

The host presents an opcode, an address, a data word and a width code, and holds `req_valid` until `req_ready` accepts them. The block then drives chip enable, write enable, address and data. Every write has a parameterised setup, pulse and hold time, counted in clock cycles. After the final write's hold time it pulses `done` and returns to idle. Polling the device for completion is left to the logic that follows. A sector erase whose address is not sector-aligned is refused with a one-cycle `err` pulse and produces no bus cycles.

Top module: `nor_cmd_seq`

## Requirements
- R1: Opcode 0 (program), outside bypass mode, emits four writes: 0xAA to unlock address A, 0x55 to unlock address B, 0xA0 to A, then `req_data` to `req_addr`.
- R2: Opcode 1 (sector erase) with an aligned address emits six writes: 0xAA@A, 0x55@B, 0x80@A, 0xAA@A, 0x55@B, then 0x30 to `req_addr`.
- R3: Opcode 2 (chip erase) emits the same first five writes as R2, then 0x10 to A.
- R4: The unlock pair (A, B) comes from the `req_width` value captured at acceptance: 0 gives 0x555/0x2AA, 1 gives 0xAAA/0x555, 2 gives 0xAAA/0x554, 3 gives 0x1555/0xAAA.
- R5: Opcode 4 emits 0xAA@A, 0x55@B, 0x20@A and then sets `bypass_active`. While `bypass_active` is set, a program emits only 0xA0 to address 0, then the data to `req_addr`.
- R6: Opcode 5 emits 0x90 then 0x00, both to address 0, and clears `bypass_active`. After this, programs use the four-write form again.
- R7: Opcode 3 emits a single write of 0xF0 to address 0.
- R8: Opcode 6 emits 0xAA@A, 0x55@B, 0x88@A. Opcode 7 emits 0xAA@A, 0x55@B, 0x90@A, 0x00@A.
- R9: In every write, chip enable is low and address and data are stable for TSU cycles before write enable falls. Write enable then stays low for exactly TWP cycles, and address and data stay for THD cycles after it rises. Consecutive writes of one command are therefore THD+TSU cycles apart.
- R10: A request is taken only when `req_ready` is high, and `req_ready` is high only when idle. A request held during a busy period waits and is carried out after the current command, never dropped.
- R11: `busy` is high from the cycle after acceptance for exactly N×(TSU+TWP+THD) cycles for an N-write command. `done` pulses for one cycle as `busy` falls. While idle, chip and write enable stay high.
- R12: A sector erase whose `req_addr` has any of its low SECTOR_BITS bits set pulses `err` for one cycle in the cycle after acceptance. It emits no write and leaves `bypass_active` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 3 | Opcode, see requirements |
| req_addr | input | AW | Target address |
| req_data | input | DW | Program data |
| req_width | input | 2 | Device width code for unlock addresses |
| busy | output | 1 | Command sequence in progress |
| done | output | 1 | One-cycle pulse at end of sequence |
| err | output | 1 | One-cycle pulse on a refused request |
| bypass_active | output | 1 | Fast-program bypass mode is on |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, held high |
| flash_addr | output | AW | Flash address bus |
| flash_dq | output | DW | Flash data to device |
| flash_dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench targets the bypass transitions. A design that ignored the mode flag would still send the three-write unlock before each program, and one that left the flag set after exit would drop the unlock writes from later programs. It tries all four width codes, because a wrong table entry writes unlock data to the wrong address. It also sends a misaligned sector erase, which a weak design would still drive onto the bus. Finally, it holds a second request during a busy period to catch a design that loses the request or interleaves its writes, and it counts setup, pulse and hold cycles to catch a phase counter that is off by one.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [2:0] {
        OP_PROG       = 3'd0,
        OP_SECT_ERASE = 3'd1,
        OP_CHIP_ERASE = 3'd2,
        OP_RESET      = 3'd3,
        OP_BYP_ENTER  = 3'd4,
        OP_BYP_EXIT   = 3'd5,
        OP_SEC_ENTER  = 3'd6,
        OP_SEC_EXIT   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        AS_UNLOCK1 = 2'd0,
        AS_UNLOCK2 = 2'd1,
        AS_BASE    = 2'd2,
        AS_TARGET  = 2'd3
    } addr_sel_e;

    typedef enum logic [1:0] {
        PH_SETUP = 2'd0,
        PH_PULSE = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;

    typedef struct packed {
        addr_sel_e   sel;
        logic        use_data;
        logic [7:0]  cmd;
        logic        last;
    } step_t;

    localparam int STEP_IDX_W = 3;

endpackage

// File: rtl/nor_unlock_sel.sv
module nor_unlock_sel #(
    parameter int AW = 24
) (
    input  logic [1:0]    width,
    output logic [AW-1:0] unlock_a,
    output logic [AW-1:0] unlock_b
);
    always_comb begin
        case (width)
            2'd0: begin
                unlock_a = AW'(13'h0555);
                unlock_b = AW'(13'h02AA);
            end
            2'd1: begin
                unlock_a = AW'(13'h0AAA);
                unlock_b = AW'(13'h0555);
            end
            2'd2: begin
                unlock_a = AW'(13'h0AAA);
                unlock_b = AW'(13'h0554);
            end
            default: begin
                unlock_a = AW'(13'h1555);
                unlock_b = AW'(13'h0AAA);
            end
        endcase
    end
endmodule

// File: rtl/nor_step_rom.sv
module nor_step_rom
    import nor_cmd_pkg::*;
(
    input  op_e                   op,
    input  logic                  short_prog,
    input  logic [STEP_IDX_W-1:0] idx,
    output step_t                 step
);
    function automatic step_t mk(addr_sel_e s, logic [7:0] c, logic u, logic l);
        step_t r;
        r.sel      = s;
        r.cmd      = c;
        r.use_data = u;
        r.last     = l;
        return r;
    endfunction

    // shared two-write unlock head used by most commands
    function automatic step_t head(logic [STEP_IDX_W-1:0] i);
        return (i == 3'd0) ? mk(AS_UNLOCK1, 8'hAA, 1'b0, 1'b0)
                           : mk(AS_UNLOCK2, 8'h55, 1'b0, 1'b0);
    endfunction

    always_comb begin
        step = mk(AS_BASE, 8'h00, 1'b0, 1'b1);
        case (op)
            OP_PROG: begin
                if (short_prog) begin
                    if (idx == 3'd0) step = mk(AS_BASE, 8'hA0, 1'b0, 1'b0);
                    else             step = mk(AS_TARGET, 8'h00, 1'b1, 1'b1);
                end else begin
                    case (idx)
                        3'd0, 3'd1: step = head(idx);
                        3'd2:       step = mk(AS_UNLOCK1, 8'hA0, 1'b0, 1'b0);
                        default:    step = mk(AS_TARGET, 8'h00, 1'b1, 1'b1);
                    endcase
                end
            end
            OP_SECT_ERASE, OP_CHIP_ERASE: begin
                case (idx)
                    3'd0, 3'd1: step = head(idx);
                    3'd2:       step = mk(AS_UNLOCK1, 8'h80, 1'b0, 1'b0);
                    3'd3:       step = head(3'd0);
                    3'd4:       step = head(3'd1);
                    default:    step = (op == OP_SECT_ERASE)
                                     ? mk(AS_TARGET, 8'h30, 1'b0, 1'b1)
                                     : mk(AS_UNLOCK1, 8'h10, 1'b0, 1'b1);
                endcase
            end
            OP_RESET: step = mk(AS_BASE, 8'hF0, 1'b0, 1'b1);
            OP_BYP_ENTER, OP_SEC_ENTER: begin
                case (idx)
                    3'd0, 3'd1: step = head(idx);
                    default:    step = mk(AS_UNLOCK1,
                                          (op == OP_BYP_ENTER) ? 8'h20 : 8'h88,
                                          1'b0, 1'b1);
                endcase
            end
            OP_BYP_EXIT: begin
                if (idx == 3'd0) step = mk(AS_BASE, 8'h90, 1'b0, 1'b0);
                else             step = mk(AS_BASE, 8'h00, 1'b0, 1'b1);
            end
            default: begin // OP_SEC_EXIT
                case (idx)
                    3'd0, 3'd1: step = head(idx);
                    3'd2:       step = mk(AS_UNLOCK1, 8'h90, 1'b0, 1'b0);
                    default:    step = mk(AS_UNLOCK1, 8'h00, 1'b0, 1'b1);
                endcase
            end
        endcase
    end
endmodule

// File: rtl/nor_wr_phase.sv
module nor_wr_phase
    import nor_cmd_pkg::*;
#(
    parameter int TSU = 2,
    parameter int TWP = 3,
    parameter int THD = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic we_low,
    output logic step_end
);
    localparam int TMAX = (TSU > TWP) ? ((TSU > THD) ? TSU : THD)
                                      : ((TWP > THD) ? TWP : THD);
    localparam int CW = (TMAX < 2) ? 1 : $clog2(TMAX);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        step_end = 1'b0;
        if (!active) begin
            st_d.ph  = PH_SETUP;
            st_d.cnt = '0;
        end else begin
            case (st_q.ph)
                PH_SETUP: begin
                    if (st_q.cnt == CW'(TSU - 1)) begin
                        st_d.ph  = PH_PULSE;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (st_q.cnt == CW'(TWP - 1)) begin
                        st_d.ph  = PH_HOLD;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (st_q.cnt == CW'(THD - 1)) begin
                        step_end = 1'b1;
                        st_d.ph  = PH_SETUP;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign we_low = active && (st_q.ph == PH_PULSE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH_SETUP;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int AW          = 24,
    parameter int DW          = 16,
    parameter int TSU         = 2,
    parameter int TWP         = 3,
    parameter int THD         = 1,
    parameter int SECTOR_BITS = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [1:0]    req_width,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          bypass_active,
    output logic          flash_ce_n,
    output logic          flash_we_n,
    output logic          flash_oe_n,
    output logic [AW-1:0] flash_addr,
    output logic [DW-1:0] flash_dq,
    output logic          flash_dq_oe
);
    typedef struct packed {
        logic                  run;
        op_e                   op;
        logic                  short_prog;
        logic [AW-1:0]         addr;
        logic [DW-1:0]         data;
        logic [1:0]            width;
        logic [STEP_IDX_W-1:0] idx;
        logic                  done;
        logic                  err;
        logic                  bypass;
    } seq_t;

    seq_t s_d, s_q;

    step_t         step;
    logic          we_low;
    logic          step_end;
    logic [AW-1:0] unlock_a;
    logic [AW-1:0] unlock_b;
    op_e           req_op_e;
    logic          misaligned;

    assign req_op_e   = op_e'(req_op);
    assign misaligned = |req_addr[SECTOR_BITS-1:0];

    nor_unlock_sel #(.AW(AW)) u_unlock (
        .width    (s_q.width),
        .unlock_a (unlock_a),
        .unlock_b (unlock_b)
    );

    nor_step_rom u_rom (
        .op         (s_q.op),
        .short_prog (s_q.short_prog),
        .idx        (s_q.idx),
        .step       (step)
    );

    nor_wr_phase #(.TSU(TSU), .TWP(TWP), .THD(THD)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (s_q.run),
        .we_low   (we_low),
        .step_end (step_end)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        if (!s_q.run && req_valid) begin
            if (req_op_e == OP_SECT_ERASE && misaligned) begin
                s_d.err = 1'b1;
            end else begin
                s_d.run        = 1'b1;
                s_d.op         = req_op_e;
                s_d.short_prog = s_q.bypass;
                s_d.addr       = req_addr;
                s_d.data       = req_data;
                s_d.width      = req_width;
                s_d.idx        = '0;
            end
        end else if (s_q.run && step_end) begin
            if (step.last) begin
                s_d.run  = 1'b0;
                s_d.done = 1'b1;
                if (s_q.op == OP_BYP_ENTER) s_d.bypass = 1'b1;
                if (s_q.op == OP_BYP_EXIT)  s_d.bypass = 1'b0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.run        <= 1'b0;
            s_q.op         <= OP_RESET;
            s_q.short_prog <= 1'b0;
            s_q.addr       <= '0;
            s_q.data       <= '0;
            s_q.width      <= '0;
            s_q.idx        <= '0;
            s_q.done       <= 1'b0;
            s_q.err        <= 1'b0;
            s_q.bypass     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        flash_addr = '0;
        if (s_q.run) begin
            case (step.sel)
                AS_UNLOCK1: flash_addr = unlock_a;
                AS_UNLOCK2: flash_addr = unlock_b;
                AS_BASE:    flash_addr = '0;
                default:    flash_addr = s_q.addr;
            endcase
        end
    end

    assign flash_dq      = !s_q.run ? '0 : (step.use_data ? s_q.data : DW'(step.cmd));
    assign flash_dq_oe   = s_q.run;
    assign flash_ce_n    = !s_q.run;
    assign flash_we_n    = !we_low;
    assign flash_oe_n    = 1'b1;
    assign req_ready     = !s_q.run;
    assign busy          = s_q.run;
    assign done          = s_q.done;
    assign err           = s_q.err;
    assign bypass_active = s_q.bypass;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int AW  = 24,
    parameter int DW  = 16,
    parameter int TWP = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          flash_ce_n,
    input logic          flash_we_n,
    input logic [AW-1:0] flash_addr,
    input logic [DW-1:0] flash_dq
);
    logic [15:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           low_cnt <= '0;
        else if (!flash_we_n) low_cnt <= low_cnt + 1'b1;
        else                  low_cnt <= '0;
    end

    assert_we_in_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> !flash_ce_n);

    assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> low_cnt == 16'(TWP));

    assert_stable_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq)));

    assert_hold_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> ($stable(flash_addr) && $stable(flash_dq)));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (flash_ce_n && flash_we_n));

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));

    assert_start_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && req_ready));

    assert_err_no_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && flash_ce_n));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW), .DW(DW), .TWP(TWP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .flash_ce_n (flash_ce_n),
    .flash_we_n (flash_we_n),
    .flash_addr (flash_addr),
    .flash_dq   (flash_dq)
);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int TSU = 2;
    localparam int TWP = 3;
    localparam int THD = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [1:0]    req_width = '0;
    logic          busy, done, err, bypass_active;
    logic          flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe;
    logic [AW-1:0] flash_addr;
    logic [DW-1:0] flash_dq;

    always #2 clk = ~clk;

    nor_cmd_seq #(.AW(AW), .DW(DW), .TSU(TSU), .TWP(TWP), .THD(THD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_width(req_width),
        .busy(busy), .done(done), .err(err), .bypass_active(bypass_active),
        .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n),
        .flash_addr(flash_addr), .flash_dq(flash_dq), .flash_dq_oe(flash_dq_oe)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail = 0;
    int writes = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    int busy_cnt = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [AW-1:0] ua(input logic [1:0] w);
        case (w)
            2'd0: return 24'h000555;
            2'd1: return 24'h000AAA;
            2'd2: return 24'h000AAA;
            default: return 24'h001555;
        endcase
    endfunction

    function automatic logic [AW-1:0] ub(input logic [1:0] w);
        case (w)
            2'd0: return 24'h0002AA;
            2'd1: return 24'h000555;
            2'd2: return 24'h000554;
            default: return 24'h000AAA;
        endcase
    endfunction

    task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        exp_t e;
        e.a = a; e.d = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // scoreboard monitor, bus timing counters, pulse counters
    logic prev_we = 1'b1;
    int   low_run = 0;
    int   high_run = 0;
    bit   first_wr = 1'b1;
    always @(negedge clk) begin
        if (done) done_cnt++;
        if (err)  err_cnt++;
        if (busy) busy_cnt++;
        if (flash_ce_n) begin
            first_wr = 1'b1;
            high_run = 0;
        end
        if (prev_we === 1'b1 && flash_we_n === 1'b0) begin
            chk(high_run == (first_wr ? TSU : THD + TSU), "R9", "setup cycles",
                high_run, first_wr ? TSU : THD + TSU);
            first_wr = 1'b0;
        end
        if (prev_we === 1'b0 && flash_we_n === 1'b1) begin
            chk(low_run == TWP, "R9", "pulse cycles", low_run, TWP);
            writes++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected write addr", flash_addr, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(flash_addr == e.a, e.tag, "write addr", flash_addr, e.a);
                chk(flash_dq == e.d, e.tag, "write data", flash_dq, e.d);
            end
            high_run = 0;
        end
        if (!flash_we_n) begin
            low_run++;
        end else begin
            low_run = 0;
            if (!flash_ce_n) high_run++;
        end
        prev_we = flash_we_n;
    end

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [1:0] w);
        req_op = op; req_addr = a; req_data = d; req_width = w;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int target, input string tag);
        while (done_cnt < target) @(negedge clk);
        chk(exp_q.size() == 0, tag, "pending writes at done", exp_q.size(), 0);
        chk(!busy, tag, "busy after done", busy, 0);
    endtask

    task automatic exp_prog(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [1:0] w, input bit byp, input string tag);
        if (byp) begin
            push(24'h0, 16'h00A0, tag);
        end else begin
            push(ua(w), 16'h00AA, tag);
            push(ub(w), 16'h0055, tag);
            push(ua(w), 16'h00A0, tag);
        end
        push(a, d, tag);
    endtask

    task automatic exp_erase_head(input logic [1:0] w, input string tag);
        push(ua(w), 16'h00AA, tag);
        push(ub(w), 16'h0055, tag);
        push(ua(w), 16'h0080, tag);
        push(ua(w), 16'h00AA, tag);
        push(ub(w), 16'h0055, tag);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R11", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        int dc;
        int wr0;
        int ec;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(flash_ce_n && flash_we_n && flash_oe_n, "R11", "reset bus idle",
            {flash_ce_n, flash_we_n, flash_oe_n}, 3'b111);
        chk(!busy && req_ready && !done && !err, "R11", "reset flags",
            {busy, req_ready, done, err}, 4'b0100);
        chk(!bypass_active, "R5", "reset bypass", bypass_active, 0);
        dc = 0;

        // R1 and R4: program under each width code, busy length checked once
        for (int w = 0; w < 4; w++) begin
            exp_prog(24'h012340 + 24'(w), 16'hBEE0 + 16'(w), 2'(w), 1'b0, (w == 0) ? "R1" : "R4");
            busy_cnt = 0;
            issue(3'd0, 24'h012340 + 24'(w), 16'hBEE0 + 16'(w), 2'(w));
            dc++;
            wait_done(dc, "R1");
            if (w == 0) chk(busy_cnt == 4 * (TSU + TWP + THD), "R11", "busy cycles",
                            busy_cnt, 4 * (TSU + TWP + THD));
        end

        // R2: aligned sector erase
        exp_erase_head(2'd0, "R2");
        push(24'h003000, 16'h0030, "R2");
        busy_cnt = 0;
        issue(3'd1, 24'h003000, 16'h0, 2'd0);
        dc++;
        wait_done(dc, "R2");
        chk(busy_cnt == 6 * (TSU + TWP + THD), "R11", "erase busy cycles",
            busy_cnt, 6 * (TSU + TWP + THD));

        // R3: chip erase, x32
        exp_erase_head(2'd3, "R3");
        push(ua(2'd3), 16'h0010, "R3");
        issue(3'd2, 24'h00ABCD, 16'h0, 2'd3);
        dc++;
        wait_done(dc, "R3");

        // R12: misaligned sector erase refused
        wr0 = writes;
        ec = err_cnt;
        issue(3'd1, 24'h003010, 16'h0, 2'd0);
        repeat (2) @(negedge clk);
        chk(err_cnt == ec + 1, "R12", "err pulses", err_cnt - ec, 1);
        chk(writes == wr0, "R12", "bus writes", writes - wr0, 0);
        chk(!busy && done_cnt == dc, "R12", "no sequence", busy, 0);
        chk(!bypass_active, "R12", "bypass unchanged", bypass_active, 0);

        // R5: enter bypass
        push(ua(2'd1), 16'h00AA, "R5");
        push(ub(2'd1), 16'h0055, "R5");
        push(ua(2'd1), 16'h0020, "R5");
        issue(3'd4, 24'h0, 16'h0, 2'd1);
        dc++;
        wait_done(dc, "R5");
        chk(bypass_active, "R5", "bypass flag set", bypass_active, 1);

        // R5 and R10: two short programs, second held while busy
        exp_prog(24'h000100, 16'h1111, 2'd1, 1'b1, "R5");
        exp_prog(24'h000102, 16'h2222, 2'd1, 1'b1, "R10");
        issue(3'd0, 24'h000100, 16'h1111, 2'd1);
        chk(busy && !req_ready, "R10", "ready low while busy", req_ready, 0);
        issue(3'd0, 24'h000102, 16'h2222, 2'd1);
        dc += 2;
        wait_done(dc, "R10");

        // R12: misaligned erase while bypass leaves flag set
        ec = err_cnt;
        issue(3'd1, 24'h000001, 16'h0, 2'd0);
        repeat (2) @(negedge clk);
        chk(err_cnt == ec + 1 && bypass_active, "R12", "bypass kept on refusal",
            bypass_active, 1);

        // R6: exit bypass, then normal program again
        push(24'h0, 16'h0090, "R6");
        push(24'h0, 16'h0000, "R6");
        issue(3'd5, 24'h055555, 16'h0, 2'd2);
        dc++;
        wait_done(dc, "R6");
        chk(!bypass_active, "R6", "bypass flag cleared", bypass_active, 0);
        exp_prog(24'h000200, 16'h3333, 2'd2, 1'b0, "R6");
        issue(3'd0, 24'h000200, 16'h3333, 2'd2);
        dc++;
        wait_done(dc, "R6");

        // R7: return to read array
        push(24'h0, 16'h00F0, "R7");
        issue(3'd3, 24'h00FFFF, 16'hFFFF, 2'd0);
        dc++;
        wait_done(dc, "R7");

        // R8: secure region enter and exit
        push(ua(2'd0), 16'h00AA, "R8");
        push(ub(2'd0), 16'h0055, "R8");
        push(ua(2'd0), 16'h0088, "R8");
        issue(3'd6, 24'h0, 16'h0, 2'd0);
        dc++;
        wait_done(dc, "R8");
        push(ua(2'd0), 16'h00AA, "R8");
        push(ub(2'd0), 16'h0055, "R8");
        push(ua(2'd0), 16'h0090, "R8");
        push(ua(2'd0), 16'h0000, "R8");
        issue(3'd7, 24'h0, 16'h0, 2'd0);
        dc++;
        wait_done(dc, "R8");

        repeat (4) @(negedge clk);
        chk(done_cnt == dc, "R11", "done pulse count", done_cnt, dc);
        report();
    end
endmodule